// File: doc/BRIEF.md
# Flash Readout Protection Access Gate

This block sits between the external access paths of an on-chip flash array and the array's byte read/write port. After reset it fetches a protection control byte from a fixed flash address, decodes it into an effective protection level (none, level 1 or level 2), and then decides, request by request, whether a read or write is passed to the flash or refused. Requests arrive tagged with an access mode: parallel programming, production-tester readout, or serial programming.

Protection closes the parallel path completely and, at level 2, the tester readout path too. The serial path stays open. Because a protected parallel path cannot write anything, the control byte's protection-reset field can only be cleared from the serial side once protection is on. A refused read answers with a zero byte and a one-cycle denial pulse. A refused write never reaches the flash.

Top module: `flash_access_guard`

## Requirements
- R1: From reset until the control byte has been read from address 0xFFDB, `ready_o` is low and `level_o` reads level 2 (encoding 2'b00 none, 2'b01 level 1, 2'b10 level 2). `ready_o` rises two clock edges after reset is released.
- R2: With the reset field (bits 5:4) not 00, bits 3:2 other than 11 give level 2, and bits 7:6 other than 11 give level 1. If both pairs request protection, level 2 wins. If both pairs are 11, the level is none.
- R3: A reset field (bits 5:4) equal to 00 gives level none, whatever the other bits hold.
- R4: Parallel-mode requests (mode 2'b00) are refused while the level is not none, and are passed to the flash when it is none.
- R5: Tester-mode reads (mode 2'b01) are passed at level none or level 1 and refused at level 2. Tester-mode writes are always refused.
- R6: Once `ready_o` is high, serial-mode requests (mode 2'b10) are passed at every level. Mode 2'b11 is always refused.
- R7: Every request gets `rsp_valid_o` one cycle later. For a refused request, `denied_o` pulses in that same cycle and `rsp_rdata_o` is 0x00. A refused write does not assert `flash_we_o`.
- R8: An accepted write to 0xFFDB stores the byte with bits 1:0 forced to 1, both in the flash and in the internal copy. `level_o` reflects the new byte from the next cycle on.
- R9: While protection is active, a parallel-mode write to 0xFFDB leaves both the flash and `level_o` unchanged. A serial-mode write can clear the protection.
- R10: Requests made while `ready_o` is low are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, one cycle per request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_mode_i | input | 2 | Access mode: 00 parallel, 01 tester, 10 serial, 11 invalid |
| req_addr_i | input | 16 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Response for the request of the previous cycle |
| rsp_rdata_o | output | 8 | Read data, 0x00 when refused |
| denied_o | output | 1 | Pulse: previous request was refused |
| ready_o | output | 1 | Control byte loaded |
| level_o | output | 2 | Effective protection level |
| flash_re_o | output | 1 | Flash read strobe |
| flash_we_o | output | 1 | Flash write strobe |
| flash_addr_o | output | 16 | Flash address |
| flash_wdata_o | output | 8 | Flash write data |
| flash_rdata_i | input | 8 | Flash read data, registered one cycle after `flash_re_o` |

## Verification
The assertions assume a flash that returns read data exactly one cycle after the read strobe. They also assume that `req_i` is the only qualifier of the request fields, so mode and address are taken as meaningful only while it is high. The bench models the flash with exactly that one-cycle latency. It holds each request for a single cycle, changes inputs only on the falling edge, and reloads the control byte through a fresh reset before each protection setting.

// File: rtl/fag_pkg.sv
package fag_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_ONE  = 2'b01,
    LVL_TWO  = 2'b10
  } prot_lvl_e;

  typedef enum logic [1:0] {
    MODE_PAR  = 2'b00,
    MODE_TEST = 2'b01,
    MODE_SER  = 2'b10,
    MODE_BAD  = 2'b11
  } acc_mode_e;

  // control byte field positions (decoded by the level logic)
  localparam int L2_LSB  = 2;
  localparam int CLR_LSB = 4;
  localparam int L1_LSB  = 6;
  localparam logic [DATA_W-1:0] RSVD_MASK = 8'h03;
endpackage

// File: rtl/fag_cfg_loader.sv
module fag_cfg_loader
  import fag_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] flash_rdata_i,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] upd_data_i,
  output logic              load_re_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] cfg_o
);
  typedef enum logic [1:0] {ST_FETCH, ST_CAPT, ST_RUN} ld_st_e;
  ld_st_e st_q;
  logic [DATA_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FETCH;
      cfg_q <= '0;
    end else begin
      unique case (st_q)
        ST_FETCH: st_q <= ST_CAPT;
        ST_CAPT: begin
          cfg_q <= flash_rdata_i;
          st_q  <= ST_RUN;
        end
        default: if (upd_i) cfg_q <= upd_data_i;
      endcase
    end
  end

  assign load_re_o = (st_q == ST_FETCH);
  assign ready_o   = (st_q == ST_RUN);
  assign cfg_o     = cfg_q;
endmodule

// File: rtl/fag_level_decode.sv
module fag_level_decode
  import fag_pkg::*;
(
  input  logic [DATA_W-1:0] cfg_i,
  input  logic              valid_i,
  output prot_lvl_e         level_o
);
  logic [1:0] l2_pair, l1_pair, clr_pair;
  assign l2_pair  = cfg_i[L2_LSB +: 2];
  assign l1_pair  = cfg_i[L1_LSB +: 2];
  assign clr_pair = cfg_i[CLR_LSB +: 2];

  always_comb begin
    if (!valid_i)              level_o = LVL_TWO;   // strictest until loaded
    else if (clr_pair == 2'b00) level_o = LVL_NONE;
    else if (l2_pair != 2'b11)  level_o = LVL_TWO;
    else if (l1_pair != 2'b11)  level_o = LVL_ONE;
    else                        level_o = LVL_NONE;
  end
endmodule

// File: rtl/fag_access_gate.sv
module fag_access_gate
  import fag_pkg::*;
(
  input  prot_lvl_e  level_i,
  input  logic       ready_i,
  input  logic [1:0] mode_i,
  input  logic       we_i,
  output logic       grant_o
);
  logic ok;
  always_comb begin
    unique case (acc_mode_e'(mode_i))
      MODE_PAR:  ok = (level_i == LVL_NONE);
      MODE_TEST: ok = !we_i && (level_i != LVL_TWO);
      MODE_SER:  ok = 1'b1;
      default:   ok = 1'b0;
    endcase
  end
  assign grant_o = ready_i && ok;
endmodule

// File: rtl/flash_access_guard.sv
module flash_access_guard
  import fag_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFDB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_mode_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_wdata_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rsp_rdata_o,
  output logic              denied_o,
  output logic              ready_o,
  output logic [1:0]        level_o,
  output logic              flash_re_o,
  output logic              flash_we_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [7:0]        flash_wdata_o,
  input  logic [7:0]        flash_rdata_i
);
  logic              load_re, ready, grant, hit_ctrl, wr_ok;
  logic [DATA_W-1:0] cfg, wdata_eff;
  prot_lvl_e         level;
  logic              vld_q, den_q, rd_ok_q;

  assign hit_ctrl  = (req_addr_i == CTRL_ADDR);
  assign wdata_eff = hit_ctrl ? (req_wdata_i | RSVD_MASK) : req_wdata_i;
  assign wr_ok     = req_i && req_we_i && grant;

  fag_cfg_loader #(.ADDR_W(ADDR_W)) u_loader (
    .clk_i, .rst_ni,
    .flash_rdata_i,
    .upd_i      (wr_ok && hit_ctrl),
    .upd_data_i (wdata_eff),
    .load_re_o  (load_re),
    .ready_o    (ready),
    .cfg_o      (cfg)
  );

  fag_level_decode u_dec (
    .cfg_i   (cfg),
    .valid_i (ready),
    .level_o (level)
  );

  fag_access_gate u_gate (
    .level_i (level),
    .ready_i (ready),
    .mode_i  (req_mode_i),
    .we_i    (req_we_i),
    .grant_o (grant)
  );

  assign flash_re_o    = load_re || (req_i && !req_we_i && grant);
  assign flash_we_o    = wr_ok;
  assign flash_addr_o  = load_re ? CTRL_ADDR : req_addr_i;
  assign flash_wdata_o = wdata_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      den_q   <= 1'b0;
      rd_ok_q <= 1'b0;
    end else begin
      vld_q   <= req_i;
      den_q   <= req_i && !grant;
      rd_ok_q <= req_i && !req_we_i && grant;
    end
  end

  assign rsp_valid_o = vld_q;
  assign denied_o    = den_q;
  assign rsp_rdata_o = rd_ok_q ? flash_rdata_i : 8'h00;
  assign ready_o     = ready;
  assign level_o     = level;
endmodule

// File: rtl/flash_access_guard_chk.sv
module flash_access_guard_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              req_we_i,
  input logic [1:0]        req_mode_i,
  input logic              rsp_valid_o,
  input logic [7:0]        rsp_rdata_o,
  input logic              denied_o,
  input logic              ready_o,
  input logic [1:0]        level_o,
  input logic              flash_re_o,
  input logic              flash_we_o
);
  p_l2_until_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> level_o == 2'b10);

  p_par_blocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o && req_mode_i == 2'b00 && level_o != 2'b00 |-> !flash_re_o && !flash_we_o);

  p_tester_l2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o && req_mode_i == 2'b01 && (level_o == 2'b10 || req_we_i) |-> !flash_re_o && !flash_we_o);

  p_serial_open_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o && req_mode_i == 2'b10 |-> flash_re_o || flash_we_o);

  p_deny_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o && !flash_re_o && !flash_we_o |=> denied_o && rsp_valid_o);

  p_deny_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    denied_o |-> rsp_rdata_o == 8'h00);

  p_one_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flash_re_o, flash_we_o}));

  p_par_ctrl_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o && req_we_i && req_mode_i == 2'b00 && level_o != 2'b00 |=> $stable(level_o));

  p_early_refuse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ready_o |=> denied_o);
endmodule

bind flash_access_guard flash_access_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .req_i, .req_we_i, .req_mode_i, .rsp_valid_o, .rsp_rdata_o,
  .denied_o, .ready_o, .level_o, .flash_re_o, .flash_we_o
);

// File: tb/flash_access_guard_tb_top.sv
module flash_access_guard_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] CTRL = 16'hFFDB;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [1:0]  mode = 0;
  logic [15:0] addr = 0;
  logic [7:0]  wdata = 0;
  logic        rsp_valid, denied, ready, f_re, f_we;
  logic [7:0]  rsp_rdata, f_wdata, f_rdata;
  logic [1:0]  level;
  logic [15:0] f_addr;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] mem [logic [15:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_access_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(we), .req_mode_i(mode),
    .req_addr_i(addr), .req_wdata_i(wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .denied_o(denied), .ready_o(ready), .level_o(level),
    .flash_re_o(f_re), .flash_we_o(f_we), .flash_addr_o(f_addr),
    .flash_wdata_o(f_wdata), .flash_rdata_i(f_rdata)
  );

  function automatic logic [7:0] peek(logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (f_re) f_rdata <= peek(f_addr);
    if (f_we) mem[f_addr] = f_wdata;
  end

  task automatic check(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic boot(logic [7:0] cfg);
    mem[CTRL] = cfg;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    while (!ready) @(negedge clk);
  endtask

  task automatic access(logic [1:0] m, logic w, logic [15:0] a, logic [7:0] d,
                        output logic [7:0] rd, output logic dn);
    @(negedge clk);
    req = 1; we = w; mode = m; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    check(rsp_valid === 1'b1, "R7", "rsp_valid", rsp_valid, 1);
    rd = rsp_rdata; dn = denied;
    @(negedge clk);
    check(denied === 1'b0, "R7", "denied one cycle", denied, 0);
  endtask

  task automatic t_reset_load();
    logic [7:0] rd; logic dn;
    mem[CTRL] = 8'hFF;
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check(ready === 1'b0 && level === 2'b10, "R1", "in reset", {ready, level}, 3'b010);
    rst_n = 1;
    // R10: request while still loading
    req = 1; mode = 2'b10; we = 0; addr = 16'h0010;
    @(negedge clk); req = 0;
    check(denied === 1'b1 && rsp_rdata === 8'h00, "R10", "early request", {denied, rsp_rdata}, 9'h100);
    check(ready === 1'b0 && level === 2'b10, "R1", "loading", {ready, level}, 3'b010);
    @(negedge clk);
    check(ready === 1'b1 && level === 2'b00, "R1", "loaded", {ready, level}, 3'b100);
    access(2'b00, 0, 16'h0020, 0, rd, dn);
    check(!dn && rd === 8'hFF, "R4", "open parallel read", rd, 8'hFF);
  endtask

  task automatic t_decode();
    logic [7:0] cfgs [6] = '{8'hF3, 8'h3F, 8'h33, 8'hFF, 8'h03, 8'hCF};
    logic [1:0] exp  [6] = '{2'b10, 2'b01, 2'b10, 2'b00, 2'b00, 2'b00};
    for (int i = 0; i < 6; i++) begin
      boot(cfgs[i]);
      check(level === exp[i], (cfgs[i][5:4] == 2'b00) ? "R3" : "R2",
            $sformatf("level cfg %0h", cfgs[i]), level, exp[i]);
    end
  endtask

  task automatic t_parallel();
    logic [7:0] rd; logic dn;
    mem[16'h0100] = 8'h5A;
    boot(8'h3F);
    access(2'b00, 0, 16'h0100, 0, rd, dn);
    check(dn && rd === 8'h00, "R4", "L1 parallel read", {dn, rd}, 9'h100);
    access(2'b00, 1, 16'h0100, 8'hA5, rd, dn);
    check(dn && peek(16'h0100) === 8'h5A, "R7", "refused write kept", peek(16'h0100), 8'h5A);
    boot(8'hFF);
    access(2'b00, 1, 16'h0100, 8'hA5, rd, dn);
    access(2'b00, 0, 16'h0100, 0, rd, dn);
    check(!dn && rd === 8'hA5, "R4", "open parallel write/read", rd, 8'hA5);
  endtask

  task automatic t_tester();
    logic [7:0] rd; logic dn;
    mem[16'h0200] = 8'h3C;
    boot(8'h3F);
    access(2'b01, 0, 16'h0200, 0, rd, dn);
    check(!dn && rd === 8'h3C, "R5", "L1 tester read", rd, 8'h3C);
    access(2'b01, 1, 16'h0200, 8'h11, rd, dn);
    check(dn && peek(16'h0200) === 8'h3C, "R5", "tester write", peek(16'h0200), 8'h3C);
    boot(8'hF3);
    access(2'b01, 0, 16'h0200, 0, rd, dn);
    check(dn && rd === 8'h00, "R5", "L2 tester read", {dn, rd}, 9'h100);
  endtask

  task automatic t_serial();
    logic [7:0] rd; logic dn;
    boot(8'h33);
    access(2'b10, 1, 16'h0300, 8'h77, rd, dn);
    access(2'b10, 0, 16'h0300, 0, rd, dn);
    check(!dn && rd === 8'h77, "R6", "L2 serial rw", rd, 8'h77);
    access(2'b11, 0, 16'h0300, 0, rd, dn);
    check(dn && rd === 8'h00, "R6", "invalid mode", {dn, rd}, 9'h100);
  endtask

  task automatic t_ctrl();
    logic [7:0] rd; logic dn;
    boot(8'h3F);
    access(2'b00, 1, CTRL, 8'hFF, rd, dn);
    check(dn && level === 2'b01 && peek(CTRL) === 8'h3F, "R9", "parallel ctrl lock",
          {level, peek(CTRL)}, {2'b01, 8'h3F});
    access(2'b10, 1, CTRL, 8'hFC, rd, dn);
    check(!dn && level === 2'b00, "R9", "serial clear", level, 0);
    access(2'b00, 0, CTRL, 0, rd, dn);
    check(rd === 8'hFF, "R8", "reserved bits forced", rd, 8'hFF);
    access(2'b00, 1, CTRL, 8'h30, rd, dn);
    check(level === 2'b10 && peek(CTRL) === 8'h33, "R8", "relock", {level, peek(CTRL)}, {2'b10, 8'h33});
    access(2'b00, 0, 16'h0000, 0, rd, dn);
    check(dn, "R8", "next request uses new level", dn, 1);
  endtask

  initial begin
    f_rdata = 8'hFF;
    t_reset_load();
    t_decode();
    t_parallel();
    t_tester();
    t_serial();
    t_ctrl();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule